// File: doc/BRIEF.md
# Configurable Output Macrocell Array

This block holds the output macrocells that sit after the OR terms of a programmable sum-of-products array. Each cell receives one OR sum and one output-enable product term. Each cell either passes the sum straight through or stores it in a D flip-flop. The cell can invert the result before it reaches the pad. It also returns one of three signals to the array as feedback: the pad's input value, the flip-flop output, or the raw sum.

All cells share three global controls: a synchronous preset term, an asynchronous clear term, and a clock selector. The clock selector takes either the dedicated pin clock or a product-term clock, in true or inverted form. The pad is modelled as three signals: drive data, drive enable, and the value seen on the pin.

Each cell has four configuration bits. Two bits pick the feedback source, one picks the output type and one picks the polarity. This gives twelve distinct behaviours per cell.

Top module: `io_macrocell_array`

## Requirements
- R1: On each rising edge of the selected clock, when preset and clear are inactive, every cell's flip-flop stores its OR sum.
- R2: When the preset term is high at a rising edge of the selected clock, every flip-flop goes to 1. The sum is ignored.
- R3: When the clear term is high, or rst_ni is low, every flip-flop reads 0 at once, with no clock edge needed. Clear beats preset when both are high.
- R4: Configuration bit 1 of a cell selects the output type. When it is 1, the pad data is the flip-flop value and does not change between clock edges. When it is 0, the pad data follows the OR sum directly.
- R5: Configuration bit 0 of a cell selects the polarity. When it is 1, the pad data equals the selected value. When it is 0, the pad data is its complement.
- R6: pad_oe_o of each cell follows that cell's output-enable term. The pad is driven only while the term is 1.
- R7: Configuration bits 3:2 of a cell select the feedback source. 01 gives the flip-flop value and 10 gives the OR sum. 00 and 11 give the pad input. The choice does not depend on the output type.
- R8: When clk_use_term_i is 1, the product-term clock clocks the flip-flops and the pin clock has no effect. When clk_invert_i is 1, the flip-flops capture on the falling edge of the chosen source instead of the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pin_i | input | 1 | Dedicated pin clock |
| clk_term_i | input | 1 | Product-term clock |
| clk_use_term_i | input | 1 | 1 selects the product-term clock |
| clk_invert_i | input | 1 | 1 inverts the chosen clock |
| rst_ni | input | 1 | Active-low asynchronous reset; clears every flip-flop |
| aclr_term_i | input | 1 | Global asynchronous clear term |
| spre_term_i | input | 1 | Global synchronous preset term |
| cfg_i | input | 4*N_CELLS | Per-cell configuration nibble; cell k uses bits 4k+3:4k |
| sum_i | input | N_CELLS | OR sum feeding each cell |
| oe_term_i | input | N_CELLS | Output-enable term for each cell |
| pad_in_i | input | N_CELLS | Value seen on each pin |
| pad_out_o | output | N_CELLS | Data driven to each pin |
| pad_oe_o | output | N_CELLS | Drive enable for each pin |
| fb_o | output | N_CELLS | Feedback returned to the array |

## Verification
Some relations are checked on every edge of the pin clock. These are: output selection and polarity against the sum or the stored bit, each feedback encoding, the stored bit being zero while clear is high, and capture and preset with the plain pin clock.

Other behaviours only the bench scenarios can show. These include clear acting between clock edges, clear beating preset, and a registered output holding while the sum moves. They also include capture on the product-term clock while pin edges are ignored, and capture on falling edges once the clock is inverted.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    FB_PIN     = 2'b00,
    FB_REG     = 2'b01,
    FB_SUM     = 2'b10,
    FB_PIN_ALT = 2'b11
  } fb_sel_e;

  typedef struct packed {
    fb_sel_e fb;
    logic    registered;
    logic    act_high;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);
endpackage

// File: rtl/mc_clk_mux.sv
module mc_clk_mux (
  input  logic pin_clk_i,
  input  logic term_clk_i,
  input  logic use_term_i,
  input  logic invert_i,
  output logic clk_o
);
  logic src;
  always_comb begin
    src   = use_term_i ? term_clk_i : pin_clk_i;
    clk_o = src ^ invert_i;
  end
endmodule

// File: rtl/mc_dff.sv
module mc_dff (
  input  logic clk_i,
  input  logic clr_i,
  input  logic preset_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i)         q_o <= 1'b0;
    else if (preset_i) q_o <= 1'b1;
    else               q_o <= d_i;
  end
endmodule

// File: rtl/mc_cell.sv
module mc_cell
  import mc_pkg::*;
(
  input  logic      clk_i,
  input  logic      clr_i,
  input  logic      preset_i,
  input  cell_cfg_t cfg_i,
  input  logic      sum_i,
  input  logic      oe_term_i,
  input  logic      pad_in_i,
  output logic      pad_out_o,
  output logic      pad_oe_o,
  output logic      fb_o,
  output logic      q_o
);
  logic q;
  logic sel_val;

  mc_dff u_dff (
    .clk_i    (clk_i),
    .clr_i    (clr_i),
    .preset_i (preset_i),
    .d_i      (sum_i),
    .q_o      (q)
  );

  always_comb begin
    sel_val   = cfg_i.registered ? q : sum_i;
    pad_out_o = cfg_i.act_high ? sel_val : ~sel_val;
    pad_oe_o  = oe_term_i;
    unique case (cfg_i.fb)
      FB_REG:  fb_o = q;
      FB_SUM:  fb_o = sum_i;
      default: fb_o = pad_in_i;
    endcase
  end

  assign q_o = q;
endmodule

// File: rtl/io_macrocell_array.sv
module io_macrocell_array
  import mc_pkg::*;
#(
  parameter int N_CELLS = 8
) (
  input  logic                       clk_pin_i,
  input  logic                       clk_term_i,
  input  logic                       clk_use_term_i,
  input  logic                       clk_invert_i,
  input  logic                       rst_ni,
  input  logic                       aclr_term_i,
  input  logic                       spre_term_i,
  input  logic [N_CELLS*CFG_W-1:0]   cfg_i,
  input  logic [N_CELLS-1:0]         sum_i,
  input  logic [N_CELLS-1:0]         oe_term_i,
  input  logic [N_CELLS-1:0]         pad_in_i,
  output logic [N_CELLS-1:0]         pad_out_o,
  output logic [N_CELLS-1:0]         pad_oe_o,
  output logic [N_CELLS-1:0]         fb_o
);
  logic               reg_clk;
  logic               clr_any;
  logic [N_CELLS-1:0] q_vec;

  assign clr_any = ~rst_ni | aclr_term_i;

  mc_clk_mux u_clk_mux (
    .pin_clk_i  (clk_pin_i),
    .term_clk_i (clk_term_i),
    .use_term_i (clk_use_term_i),
    .invert_i   (clk_invert_i),
    .clk_o      (reg_clk)
  );

  for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
    cell_cfg_t cell_cfg;
    assign cell_cfg = cell_cfg_t'(cfg_i[k*CFG_W +: CFG_W]);

    mc_cell u_cell (
      .clk_i     (reg_clk),
      .clr_i     (clr_any),
      .preset_i  (spre_term_i),
      .cfg_i     (cell_cfg),
      .sum_i     (sum_i[k]),
      .oe_term_i (oe_term_i[k]),
      .pad_in_i  (pad_in_i[k]),
      .pad_out_o (pad_out_o[k]),
      .pad_oe_o  (pad_oe_o[k]),
      .fb_o      (fb_o[k]),
      .q_o       (q_vec[k])
    );
  end
endmodule

// File: rtl/mc_checker.sv
module mc_checker
  import mc_pkg::*;
#(
  parameter int N_CELLS = 8
) (
  input logic                     clk_pin_i,
  input logic                     rst_ni,
  input logic                     clk_use_term_i,
  input logic                     clk_invert_i,
  input logic                     aclr_term_i,
  input logic                     spre_term_i,
  input logic [N_CELLS*CFG_W-1:0] cfg_i,
  input logic [N_CELLS-1:0]       sum_i,
  input logic [N_CELLS-1:0]       pad_in_i,
  input logic [N_CELLS-1:0]       pad_out_o,
  input logic [N_CELLS-1:0]       fb_o,
  input logic [N_CELLS-1:0]       q_i
);
  logic plain_clk;
  assign plain_clk = !clk_use_term_i && !clk_invert_i;

  for (genvar k = 0; k < N_CELLS; k++) begin : g_chk
    logic [1:0] fb_k;
    logic       reg_k;
    logic       hi_k;
    assign fb_k  = cfg_i[k*CFG_W+2 +: 2];
    assign reg_k = cfg_i[k*CFG_W+1];
    assign hi_k  = cfg_i[k*CFG_W];

    AST_COMB_OUT: assert property (@(posedge clk_pin_i) disable iff (!rst_ni)
      !reg_k |-> pad_out_o[k] == (sum_i[k] ^ !hi_k)); // R4
    AST_REG_OUT: assert property (@(posedge clk_pin_i) disable iff (!rst_ni)
      reg_k |-> pad_out_o[k] == (q_i[k] ^ !hi_k)); // R5
    AST_FB_SUM: assert property (@(posedge clk_pin_i) disable iff (!rst_ni)
      fb_k == 2'b10 |-> fb_o[k] == sum_i[k]); // R7
    AST_FB_REG: assert property (@(posedge clk_pin_i) disable iff (!rst_ni)
      fb_k == 2'b01 |-> fb_o[k] == q_i[k]); // R7
    AST_FB_PIN: assert property (@(posedge clk_pin_i) disable iff (!rst_ni)
      fb_k[1] == fb_k[0] |-> fb_o[k] == pad_in_i[k]); // R7
    AST_CLEAR_LOW: assert property (@(posedge clk_pin_i) disable iff (!rst_ni)
      aclr_term_i |-> !q_i[k]); // R3
    AST_PRESET_SET: assert property (@(posedge clk_pin_i) disable iff (!rst_ni)
      (plain_clk && spre_term_i && !aclr_term_i) |=>
      (!plain_clk || aclr_term_i || q_i[k])); // R2
    AST_CAPTURE: assert property (@(posedge clk_pin_i) disable iff (!rst_ni)
      (plain_clk && !spre_term_i && !aclr_term_i) |=>
      (!plain_clk || aclr_term_i || q_i[k] == $past(sum_i[k]))); // R1
  end
endmodule

bind io_macrocell_array mc_checker #(.N_CELLS(N_CELLS)) u_mc_checker (
  .clk_pin_i      (clk_pin_i),
  .rst_ni         (rst_ni),
  .clk_use_term_i (clk_use_term_i),
  .clk_invert_i   (clk_invert_i),
  .aclr_term_i    (aclr_term_i),
  .spre_term_i    (spre_term_i),
  .cfg_i          (cfg_i),
  .sum_i          (sum_i),
  .pad_in_i       (pad_in_i),
  .pad_out_o      (pad_out_o),
  .fb_o           (fb_o),
  .q_i            (q_vec)
);

// File: tb/tb_io_macrocell_array.sv
`timescale 1ns/1ps
module tb_io_macrocell_array;
  localparam int N = 8;

  logic         clk_pin = 1'b0;
  logic         clk_term, use_term, invert, rst_n, aclr, spre;
  logic [4*N-1:0] cfg;
  logic [N-1:0] sum, oe, pad_in;
  logic [N-1:0] pad_out, pad_oe, fb;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk_pin = ~clk_pin;

  io_macrocell_array #(.N_CELLS(N)) dut (
    .clk_pin_i      (clk_pin),
    .clk_term_i     (clk_term),
    .clk_use_term_i (use_term),
    .clk_invert_i   (invert),
    .rst_ni         (rst_n),
    .aclr_term_i    (aclr),
    .spre_term_i    (spre),
    .cfg_i          (cfg),
    .sum_i          (sum),
    .oe_term_i      (oe),
    .pad_in_i       (pad_in),
    .pad_out_o      (pad_out),
    .pad_oe_o       (pad_oe),
    .fb_o           (fb)
  );

  // {cfg, sum, pad_in, oe, exp_out, exp_fb}; expected oe equals oe
  localparam logic [47:0] VEC [6] = '{
    48'h01_A5_3C_FF_A5_3C,
    48'h00_A5_3C_0F_5A_3C,
    48'h09_96_00_F0_96_96,
    48'h08_96_FF_33_69_96,
    48'h0D_0F_C3_00_0F_C3,
    48'h0C_FF_81_FF_00_81
  };

  function automatic logic [4*N-1:0] rep(input logic [3:0] c);
    return {N{c}};
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic nedge();
    @(negedge clk_pin);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_pin);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    clk_term = 0; use_term = 0; invert = 0; rst_n = 0; aclr = 0; spre = 0;
    cfg = rep(4'b0111); sum = 8'hC3; oe = 8'hFF; pad_in = 8'h00;
    repeat (3) nedge();
    check("R3 reset fb", fb, 8'h00);
    check("R3 reset out", pad_out, 8'h00);
    cfg = rep(4'b0110); #1;
    check("R5 reset active-low out", pad_out, 8'hFF);
    cfg = rep(4'b0111);
    rst_n = 1;
    nedge();
    check("R1 capture fb", fb, 8'hC3);
    check("R4 registered out", pad_out, 8'hC3);

    for (int i = 0; i < 6; i++) begin
      cfg = rep(VEC[i][43:40]); sum = VEC[i][39:32];
      pad_in = VEC[i][31:24]; oe = VEC[i][23:16];
      #1;
      check("R4/R5 comb out", pad_out, VEC[i][15:8]);
      check("R7 feedback", fb, VEC[i][7:0]);
      check("R6 oe", pad_oe, VEC[i][23:16]);
      nedge();
    end

    cfg = rep(4'b0111); oe = 8'hFF; sum = 8'hC3;
    nedge();
    sum = 8'h3C; #1;
    check("R4 registered holds", pad_out, 8'hC3);
    nedge();
    check("R4 registered updates", pad_out, 8'h3C);

    spre = 1; sum = 8'h00;
    nedge();
    check("R2 preset", fb, 8'hFF);
    spre = 0;

    aclr = 1; #1;
    check("R3 async clear", fb, 8'h00);
    spre = 1; sum = 8'hFF;
    nedge();
    check("R3 clear beats preset", fb, 8'h00);
    aclr = 0; spre = 0; sum = 8'hA5;
    nedge();
    check("R1 capture after clear", fb, 8'hA5);

    cfg = rep(4'b0101); sum = 8'h5A; #1;
    check("R7 reg fb comb out", pad_out, 8'h5A);
    check("R7 reg fb holds", fb, 8'hA5);
    nedge();
    check("R7 reg fb updates", fb, 8'h5A);

    cfg = rep(4'b0111);
    use_term = 1; sum = 8'h0F;
    nedge();
    check("R8 pin clock ignored", fb, 8'h5A);
    clk_term = 1; #1;
    check("R8 term clock capture", fb, 8'h0F);
    clk_term = 0; #1;
    invert = 1; #1;
    sum = 8'hF0;
    clk_term = 1; #1;
    check("R8 inverted term rise ignored", fb, 8'h0F);
    clk_term = 0; #1;
    check("R8 inverted term fall capture", fb, 8'hF0);

    nedge();
    use_term = 0; sum = 8'h66;
    @(posedge clk_pin); #1;
    check("R8 inverted pin rise ignored", fb, 8'hF0);
    nedge();
    check("R8 inverted pin fall capture", fb, 8'h66);
    invert = 0;
    nedge();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule